// File: doc/BRIEF.md
# Processor Idle-State Break and Throttle Controller

This block sequences a processor through the idle states C2, C3 and C4 and through software-requested clock throttling. Software issues a level read with a two-bit depth code. The controller enters the matching idle state on the next clock and holds its stop-clock output active. It stays there until a qualified break event arrives, and the kind of event that qualifies depends on how deep the idle state is. Interrupts that are not masked, NMI, SMI and INIT events break from every idle state. A pending-break indication also breaks from every idle state, but only when its enable bit is set. A bus-master request breaks only from C3 or C4, and only when the bus-master reload bit is set. A second configuration bit can turn a bus-master break into a drop back to C2.

While the controller is running, throttling gates the stop-clock output for a programmable fraction of a 1024-clock period. A free-running counter sets that period, and throttling starts only at a counter wrap. So after a break exit the first throttle assertion can lag by up to one full period. Sleep enable overrides both features: it suppresses throttling, and it blocks any new entry to an idle state.

Top module: `cpu_idle_throttle`

## Requirements
- R1: After reset, `state_o` is 0 (running), `stop_clk_o` is 0, and the period counter starts at 0 on the first clock after reset.
- R2: In the running state, a level read with `lvl_code` 1, 2 or 3 moves `state_o` to 1 (C2), 2 (C3) or 3 (C4) on the next clock edge. A read with code 0 has no effect.
- R3: While `state_o` is nonzero, `stop_clk_o` is 1, and a level read has no effect on `state_o`.
- R4: While `slp_en` is 1, a level read leaves the controller in the running state.
- R5: In any idle state, an interrupt bit set in `irq_req` with its `irq_mask` bit clear, or `nmi_evt`, `smi_evt` or `init_evt`, returns `state_o` to 0 on the next edge. An interrupt whose mask bit is set has no effect.
- R6: `pend_brk` breaks any idle state to running only when `pend_brk_en` is 1.
- R7: `bm_req` together with `bm_reload` returns C3 or C4 to running. The request has no effect in C2, or when `bm_reload` is 0.
- R8: When `bm_to_c2` is 1, a qualifying bus-master request moves C3 or C4 to C2 instead of running. A general break in the same cycle takes precedence and returns to running.
- R9: While throttling is armed and effective, `stop_clk_o` is 1 exactly in the cycles where the top three bits of the 10-bit period counter are below `thr_duty`. A duty of 0 never asserts.
- R10: Throttling arms only when the counter wraps from 1023 to 0 while the controller is running with throttling effective. It disarms in any idle state, so after a break exit there is no throttle assertion before the next wrap.
- R11: While `slp_en` is 1, `thr_en` and `thr_force` are treated as 0: in the running state `stop_clk_o` is 0 at once, and throttling disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_rd | input | 1 | Level read strobe |
| lvl_code | input | 2 | Requested depth: 1=C2, 2=C3, 3=C4, 0=none |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_mask | input | NUM_IRQ | Interrupt mask, 1 = masked |
| nmi_evt | input | 1 | NMI source active |
| smi_evt | input | 1 | SMI source active |
| init_evt | input | 1 | INIT source active |
| bm_req | input | 1 | Bus-master request |
| bm_reload | input | 1 | Bus-master request may break C3/C4 |
| bm_to_c2 | input | 1 | Bus-master break goes to C2 instead |
| pend_brk | input | 1 | Processor pending-break indication |
| pend_brk_en | input | 1 | Enable for the pending-break indication |
| thr_en | input | 1 | Throttle enable |
| thr_force | input | 1 | Force throttle |
| slp_en | input | 1 | Sleep entry in progress |
| thr_duty | input | 3 | Throttle duty in eighths of the period |
| stop_clk_o | output | 1 | Stop-clock request, active high |
| state_o | output | 2 | Current state: 0 run, 1 C2, 2 C3, 3 C4 |

## Verification
The bench probes the bus-master corner: requests without reload, requests in C2, and requests that coincide with an NMI while the demote-to-C2 bit is set. A design that qualified requests too loosely would leave C2 or ignore reload, and one with the precedence reversed would land in C2 instead of running. It also checks that throttling does not restart before the next counter wrap after a break exit. A design that rearmed at once would assert stop-clock in the middle of a period. Level reads issued while idle or during sleep entry are checked too, since a design that accepted them would change depth or leave the running state.

// File: rtl/idle_thr_pkg.sv
package idle_thr_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_C2  = 2'd1,
        ST_C3  = 2'd2,
        ST_C4  = 2'd3
    } cstate_e;

    // Qualified break classes for the current cycle
    typedef struct packed {
        logic general;   // any source that returns to running
        logic bm_hit;    // qualified bus-master activity in a deep state
    } brk_t;

    // Depth code of a level read maps directly onto the state encoding
    function automatic cstate_e depth_to_state(input logic [1:0] code);
        return cstate_e'(code);
    endfunction

    function automatic logic is_deep(input cstate_e s);
        return (s == ST_C3) || (s == ST_C4);
    endfunction

endpackage

// File: rtl/idle_break_qual.sv
module idle_break_qual
    import idle_thr_pkg::*;
#(
    parameter int NUM_IRQ = 24
) (
    input  cstate_e              cur_state,
    input  logic [NUM_IRQ-1:0]   irq_req,
    input  logic [NUM_IRQ-1:0]   irq_mask,
    input  logic                 nmi_evt,
    input  logic                 smi_evt,
    input  logic                 init_evt,
    input  logic                 pend_brk,
    input  logic                 pend_brk_en,
    input  logic                 bm_req,
    input  logic                 bm_reload,
    output brk_t                 brk
);

    logic [NUM_IRQ-1:0] irq_live;
    logic               any_irq;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign irq_live[i] = irq_req[i] & ~irq_mask[i];
    end

    assign any_irq = |irq_live;

    always_comb begin
        brk.general = any_irq | nmi_evt | smi_evt | init_evt
                    | (pend_brk & pend_brk_en);
        brk.bm_hit  = bm_req & bm_reload & is_deep(cur_state);
    end

endmodule

// File: rtl/idle_state_fsm.sv
module idle_state_fsm
    import idle_thr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_rd,
    input  logic [1:0] lvl_code,
    input  logic       slp_en,
    input  logic       bm_to_c2,
    input  brk_t       brk,
    output cstate_e    state_q
);

    cstate_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (lvl_rd && !slp_en && (lvl_code != 2'd0))
                    state_d = depth_to_state(lvl_code);
            end
            default: begin
                if (brk.general)
                    state_d = ST_RUN;
                else if (brk.bm_hit)
                    state_d = bm_to_c2 ? ST_C2 : ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/throttle_gen.sv
module throttle_gen #(
    parameter int PERIOD_W = 10,
    parameter int DUTY_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_on,
    input  logic              in_run,
    input  logic [DUTY_W-1:0] duty,
    output logic              thr_stop
);

    localparam logic [PERIOD_W-1:0] CNT_MAX = {PERIOD_W{1'b1}};

    logic [PERIOD_W-1:0] period_cnt;
    logic                armed_q;
    logic [DUTY_W-1:0]   slot;

    always_ff @(posedge clk) begin
        if (rst) period_cnt <= '0;
        else     period_cnt <= period_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (!in_run || !thr_on)
            armed_q <= 1'b0;
        else if (period_cnt == CNT_MAX)
            armed_q <= 1'b1;
    end

    assign slot     = period_cnt[PERIOD_W-1 -: DUTY_W];
    assign thr_stop = armed_q & thr_on & (slot < duty);

endmodule

// File: rtl/cpu_idle_throttle.sv
module cpu_idle_throttle
    import idle_thr_pkg::*;
#(
    parameter int NUM_IRQ  = 24,
    parameter int PERIOD_W = 10,
    parameter int DUTY_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lvl_rd,
    input  logic [1:0]         lvl_code,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               nmi_evt,
    input  logic               smi_evt,
    input  logic               init_evt,
    input  logic               bm_req,
    input  logic               bm_reload,
    input  logic               bm_to_c2,
    input  logic               pend_brk,
    input  logic               pend_brk_en,
    input  logic               thr_en,
    input  logic               thr_force,
    input  logic               slp_en,
    input  logic [DUTY_W-1:0]  thr_duty,
    output logic               stop_clk_o,
    output logic [1:0]         state_o
);

    cstate_e cur_state;
    brk_t    brk;
    logic    thr_on;
    logic    thr_stop;

    // Sleep entry overrides both throttle request bits
    assign thr_on = (thr_en | thr_force) & ~slp_en;

    idle_break_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
        .cur_state   (cur_state),
        .irq_req     (irq_req),
        .irq_mask    (irq_mask),
        .nmi_evt     (nmi_evt),
        .smi_evt     (smi_evt),
        .init_evt    (init_evt),
        .pend_brk    (pend_brk),
        .pend_brk_en (pend_brk_en),
        .bm_req      (bm_req),
        .bm_reload   (bm_reload),
        .brk         (brk)
    );

    idle_state_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lvl_rd   (lvl_rd),
        .lvl_code (lvl_code),
        .slp_en   (slp_en),
        .bm_to_c2 (bm_to_c2),
        .brk      (brk),
        .state_q  (cur_state)
    );

    throttle_gen #(.PERIOD_W(PERIOD_W), .DUTY_W(DUTY_W)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .thr_on   (thr_on),
        .in_run   (cur_state == ST_RUN),
        .duty     (thr_duty),
        .thr_stop (thr_stop)
    );

    assign state_o    = cur_state;
    assign stop_clk_o = (cur_state != ST_RUN) | thr_stop;

endmodule

// File: rtl/idle_thr_chk.sv
module idle_thr_chk #(
    parameter int NUM_IRQ = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               lvl_rd,
    input logic [1:0]         lvl_code,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic [NUM_IRQ-1:0] irq_mask,
    input logic               nmi_evt,
    input logic               smi_evt,
    input logic               init_evt,
    input logic               bm_req,
    input logic               pend_brk,
    input logic               pend_brk_en,
    input logic               slp_en,
    input logic               stop_clk_o,
    input logic [1:0]         state_o
);

    logic quiet;
    assign quiet = ~|(irq_req & ~irq_mask) & !nmi_evt & !smi_evt & !init_evt
                 & !bm_req & !(pend_brk & pend_brk_en);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_o == 2'd0));

    // R2
    level_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && lvl_rd && !slp_en && lvl_code != 2'd0)
        |=> (state_o == $past(lvl_code)));

    // R3
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0) |-> stop_clk_o);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0 && quiet) |=> $stable(state_o));

    // R4
    sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && slp_en) |=> (state_o == 2'd0));

    // R5
    hard_break_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0 && (nmi_evt || smi_evt || init_evt)) |=> (state_o == 2'd0));

    // R11
    sleep_nothrottle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && slp_en) |-> !stop_clk_o);

endmodule

bind cpu_idle_throttle idle_thr_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/test_cpu_idle_throttle.sv
module test_cpu_idle_throttle;

    localparam int NI = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lvl_rd = 0;
    logic [1:0]    lvl_code = 0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_mask = '0;
    logic nmi_evt = 0, smi_evt = 0, init_evt = 0, bm_req = 0, bm_reload = 0;
    logic bm_to_c2 = 0, pend_brk = 0, pend_brk_en = 0;
    logic thr_en = 0, thr_force = 0, slp_en = 0;
    logic [2:0]    thr_duty = 0;
    logic          stop_clk_o;
    logic [1:0]    state_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_tag = "R1";

    // bench model
    int m_state = 0;
    int m_cnt = 0;
    bit m_arm = 0;

    always #5 clk = ~clk;

    cpu_idle_throttle #(.NUM_IRQ(NI)) i_cpu_idle_throttle (.*);

    function automatic bit thr_eff();
        return (thr_en | thr_force) & ~slp_en;
    endfunction

    function automatic bit exp_stop();
        return (m_state != 0) || (m_arm && thr_eff() && ((m_cnt >> 7) < int'(thr_duty)));
    endfunction

    always @(posedge clk) begin
        int nxt;
        bit gen, bmh;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_arm = 0;
        end else begin
            gen = (|(irq_req & ~irq_mask)) | nmi_evt | smi_evt | init_evt | (pend_brk & pend_brk_en);
            bmh = bm_req & bm_reload & (m_state >= 2);
            nxt = m_state;
            if (m_state == 0) begin
                if (lvl_rd && !slp_en && lvl_code != 0) nxt = int'(lvl_code);
            end else if (gen) nxt = 0;
            else if (bmh) nxt = bm_to_c2 ? 1 : 0;
            if (m_state != 0 || !thr_eff()) m_arm = 0;
            else if (m_cnt == 1023) m_arm = 1;
            m_cnt = (m_cnt + 1) % 1024;
            m_state = nxt;
        end
    end

    task automatic cyc();
        @(negedge clk);
        checks++;
        if (int'(state_o) != m_state) begin
            errors++;
            $display("FAIL %s state actual=%0d expected=%0d at %0t", cur_tag, state_o, m_state, $time);
        end
        checks++;
        if (stop_clk_o !== exp_stop()) begin
            errors++;
            $display("FAIL %s stop_clk actual=%0b expected=%0b at %0t", cur_tag, stop_clk_o, exp_stop(), $time);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic enter(input logic [1:0] code);
        lvl_rd = 1; lvl_code = code; cyc(); lvl_rd = 0; lvl_code = 0; cyc();
    endtask

    task automatic clear_events();
        irq_req = '0; nmi_evt = 0; smi_evt = 0; init_evt = 0; bm_req = 0; pend_brk = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        run(3);
        rst = 0;
        cur_tag = "R1"; cyc();
        // R2 entries and code 0
        cur_tag = "R2";
        enter(2'd0); enter(2'd1);
        nmi_evt = 1; cyc(); nmi_evt = 0; cyc();
        enter(2'd2); irq_req[5] = 1; cyc(); clear_events(); cyc();
        enter(2'd3); smi_evt = 1; cyc(); clear_events(); cyc();
        // R3 read while idle
        cur_tag = "R3";
        enter(2'd3); enter(2'd1); run(3);
        init_evt = 1; cyc(); clear_events(); cyc();
        // R4 read during sleep entry
        cur_tag = "R4";
        slp_en = 1; enter(2'd2); slp_en = 0; cyc();
        // R5 masked interrupt, then INIT
        cur_tag = "R5";
        enter(2'd1); irq_mask = '1; irq_req = '1; run(3);
        irq_mask[23] = 0; cyc(); clear_events(); irq_mask = '0;
        enter(2'd2); init_evt = 1; cyc(); clear_events(); cyc();
        // R6 pending break
        cur_tag = "R6";
        enter(2'd3); pend_brk = 1; run(3); pend_brk_en = 1; cyc(); clear_events(); pend_brk_en = 0; cyc();
        // R7 bus master
        cur_tag = "R7";
        enter(2'd1); bm_req = 1; bm_reload = 1; run(3); bm_req = 0; nmi_evt = 1; cyc(); clear_events();
        enter(2'd2); bm_reload = 0; bm_req = 1; run(3); bm_reload = 1; cyc(); clear_events(); cyc();
        enter(2'd3); bm_req = 1; cyc(); clear_events(); cyc();
        // R8 demote to C2, precedence
        cur_tag = "R8";
        bm_to_c2 = 1;
        enter(2'd3); bm_req = 1; cyc(); run(2); bm_req = 0; smi_evt = 1; cyc(); clear_events();
        enter(2'd2); bm_req = 1; nmi_evt = 1; cyc(); clear_events(); bm_to_c2 = 0; bm_reload = 0; cyc();
        // R9 throttle duty
        cur_tag = "R9";
        thr_en = 1; thr_duty = 3; run(2500);
        thr_duty = 0; run(1100);
        thr_en = 0; thr_force = 1; thr_duty = 7; run(1100);
        // R10 break exit waits for wrap
        cur_tag = "R10";
        thr_duty = 4; run(300);
        enter(2'd2); run(5); nmi_evt = 1; cyc(); clear_events(); run(2100);
        // R11 sleep overrides throttle
        cur_tag = "R11";
        run(100); slp_en = 1; run(300); slp_en = 0; run(1500); thr_force = 0;
        // random mix
        cur_tag = "R8";
        for (int i = 0; i < 8000; i++) begin
            lvl_rd = ($urandom % 6) == 0; lvl_code = 2'($urandom);
            irq_req = '0; irq_req[$urandom % NI] = ($urandom % 20) == 0;
            irq_mask = ($urandom % 2) ? '1 : '0;
            nmi_evt = ($urandom % 60) == 0; smi_evt = ($urandom % 60) == 0;
            init_evt = ($urandom % 60) == 0; bm_req = ($urandom % 8) == 0;
            bm_reload = $urandom % 2; bm_to_c2 = $urandom % 2;
            pend_brk = ($urandom % 10) == 0; pend_brk_en = $urandom % 2;
            if (i % 700 == 0) begin
                thr_en = $urandom % 2; thr_force = $urandom % 2; thr_duty = 3'($urandom);
                slp_en = ($urandom % 4) == 0;
            end
            cyc();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule